// File: doc/BRIEF.md
# Master/Slave Switching Clock Synchronizer

This block produces the switching clock of a phase-shifted bridge controller and keeps several such controllers in step over one shared sync wire. A static role input makes the instance either the master, which drives the wire, or a slave, which only listens. The internal clock period is a programmable number of system clock cycles. Two phase outputs, A and B, take turns on successive internal clock cycles, so each one switches at half the internal clock rate.

A master drives the sync wire with its internal clock once the enable input is high. That gives pulses at twice the switching frequency with a 50% duty cycle. A slave synchronizes the wire through a flop chain and restarts its internal cycle on every falling edge it sees. The master's falling edge comes half an internal cycle into the master's period, so the slave runs a quarter of the switching period behind the master. A slave does not switch until the first falling edge arrives. After that it keeps running on its own counter if the pulses stop. A flag reports when the edges arrive too slowly for valid slave operation.

Top module: `sws_clk_sync`

## Requirements
- R1: In master mode (`slave_mode`=0), `sync_drive` is 1 and `sync_out` equals `clk_int`. With period P it repeats every P cycles and is high for floor(P/2) of them.
- R2: In slave mode (`slave_mode`=1), `sync_drive` and `sync_out` are always 0.
- R3: In slave mode while running, a falling edge on `sync_in` restarts the internal cycle. The edge is sampled before clock edge k, and after edge k+2 `clk_int` is 1 with the counter at the start of a cycle. An edge that arrives before the natural wrap shortens the cycle.
- R4: In slave mode with `enable`=1, `running` stays 0 until the first falling edge of `sync_in` is detected. It becomes 1 after the same clock edge named in R3.
- R5: Once a slave is running, it keeps running with `enable` high even when `sync_in` stops toggling. `clk_int` then free-runs with period P.
- R6: In master mode, `running` becomes 1 on the first clock edge at which `enable` is seen high, and `sync_out` is 0 before that. In either mode, `enable`=0 clears `running` at the next edge. While `running` is 0, `clk_int`, `out_a` and `out_b` are 0.
- R7: `out_a` is 1 for the whole first internal cycle after start. `out_b` is 1 for the next cycle, and the two keep alternating. They are never 1 together.
- R8: The internal counter runs from 0 to P-1. `clk_int` is 1 while the count is below floor(P/2). A programmed P of 0 or 1 is treated as 2.
- R9: In slave mode while running, `sync_slow` goes to 1 once the number of clocks since the last detected falling edge, G, satisfies 9*G > 10*P. On each detected falling edge it is reloaded with that comparison. It is 0 in master mode and while not running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| slave_mode | input | 1 | Static role: 0 master, 1 slave |
| enable | input | 1 | Start permission (soft-start past threshold) |
| period | input | CNT_W | Internal clock period in clock cycles |
| sync_in | input | 1 | Shared sync line as received |
| sync_out | output | 1 | Sync level to drive onto the line |
| sync_drive | output | 1 | Drive enable for the sync line (master only) |
| clk_int | output | 1 | Internal switching clock |
| out_a | output | 1 | Phase A, active on alternate internal cycles |
| out_b | output | 1 | Phase B, active on the other cycles |
| running | output | 1 | Block is switching |
| sync_slow | output | 1 | Incoming sync edges too far apart |

## Verification
The bench uses CNT_W=16 and two synchronizer stages, and sets the period to 20 for most scenarios. That value puts the slow-sync limit at 23 clocks, so a 20-cycle sync passes, an 18-cycle sync exercises early realignment, and a 40-cycle sync or a stopped line trips the flag. A programmed period of 1 is used to show the clamp to 2, where the master sync toggles every cycle. The three-edge latency from a falling sync edge to the slave's cycle start is measured directly, both at start-up and in steady lock.

// File: rtl/sws_pkg.sv
`timescale 1ns/1ps
package sws_pkg;

    typedef enum logic {
        ROLE_MASTER = 1'b0,
        ROLE_SLAVE  = 1'b1
    } role_e;

    typedef struct packed {
        logic fall;
        logic level;
    } edge_t;

    typedef struct packed {
        logic run;
        logic sel;
    } gen_state_t;

    localparam int MIN_PERIOD = 2;
    localparam int SLOW_NUM   = 9;
    localparam int SLOW_DEN   = 10;

    function automatic logic [31:0] eff_period(input logic [31:0] p);
        return (p < 32'(MIN_PERIOD)) ? 32'(MIN_PERIOD) : p;
    endfunction

    function automatic logic gap_too_long(input logic [31:0] gap, input logic [31:0] per);
        logic [39:0] lhs;
        logic [39:0] rhs;
        lhs = {8'd0, gap} * 40'(SLOW_NUM);
        rhs = {8'd0, per} * 40'(SLOW_DEN);
        return lhs > rhs;
    endfunction

endpackage

// File: rtl/sws_edge_sync.sv
`timescale 1ns/1ps
module sws_edge_sync
    import sws_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  din,
    output edge_t evt
);
    logic [STAGES-1:0] chain;
    logic              last;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
            last  <= 1'b0;
        end else begin
            chain <= {chain[STAGES-2:0], din};
            last  <= chain[STAGES-1];
        end
    end

    always_comb begin
        evt.level = chain[STAGES-1];
        evt.fall  = last & ~chain[STAGES-1];
    end

endmodule

// File: rtl/sws_period_gen.sv
`timescale 1ns/1ps
module sws_period_gen
    import sws_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  role_e            role,
    input  logic             enable,
    input  logic             fall,
    input  logic [CNT_W-1:0] period,
    output logic             running,
    output logic             clk_int,
    output logic             out_a,
    output logic             out_b
);
    logic [CNT_W-1:0] per_eff;
    logic [CNT_W-1:0] half;
    logic [CNT_W-1:0] cnt;
    gen_state_t       st;
    logic             run_d;
    logic             wrap;
    logic             realign;

    always_comb begin
        per_eff = CNT_W'(eff_period(32'(period)));
        half    = per_eff >> 1;
        wrap    = (cnt >= per_eff - 1'b1);
        realign = (role == ROLE_SLAVE) && fall;
        if (!enable)                 run_d = 1'b0;
        else if (role == ROLE_MASTER) run_d = 1'b1;
        else                         run_d = st.run | fall;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= '0;
            cnt <= '0;
        end else begin
            st.run <= run_d;
            if (!run_d || !st.run) begin
                cnt    <= '0;
                st.sel <= 1'b0;
            end else if (realign || wrap) begin
                cnt    <= '0;
                st.sel <= ~st.sel;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    always_comb begin
        running = st.run;
        clk_int = st.run && (cnt < half);
        out_a   = st.run && !st.sel;
        out_b   = st.run && st.sel;
    end

    AST_HOLDOFF: assert property (@(posedge clk) disable iff (rst)
        ($rose(st.run) && role == ROLE_SLAVE) |-> $past(fall)); // R4
    AST_EN_GATE: assert property (@(posedge clk) disable iff (rst)
        st.run |-> $past(enable)); // R6
    AST_KEEP_RUN: assert property (@(posedge clk) disable iff (rst)
        (st.run && enable) |=> st.run); // R5
    AST_REALIGN: assert property (@(posedge clk) disable iff (rst)
        (st.run && enable && role == ROLE_SLAVE && fall) |=> (cnt == '0)); // R3

endmodule

// File: rtl/sws_rate_mon.sv
`timescale 1ns/1ps
module sws_rate_mon
    import sws_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             active,
    input  logic             fall,
    input  logic [CNT_W-1:0] period,
    output logic             sync_slow
);
    localparam int GW = CNT_W + 2;

    logic [GW-1:0] gap;
    logic          too_long;
    logic [31:0]   per_eff;

    always_comb begin
        per_eff  = eff_period(32'(period));
        too_long = gap_too_long(32'(gap), per_eff);
    end

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            gap       <= '0;
            sync_slow <= 1'b0;
        end else if (fall) begin
            gap       <= '0;
            sync_slow <= too_long;
        end else begin
            if (gap != {GW{1'b1}}) gap <= gap + 1'b1;
            if (too_long) sync_slow <= 1'b1;
        end
    end

    AST_SLOW_HOLD: assert property (@(posedge clk) disable iff (rst)
        (active && sync_slow && !fall) |=> (sync_slow || !active)); // R9

endmodule

// File: rtl/sws_clk_sync.sv
`timescale 1ns/1ps
module sws_clk_sync
    import sws_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             slave_mode,
    input  logic             enable,
    input  logic [CNT_W-1:0] period,
    input  logic             sync_in,
    output logic             sync_out,
    output logic             sync_drive,
    output logic             clk_int,
    output logic             out_a,
    output logic             out_b,
    output logic             running,
    output logic             sync_slow
);
    role_e role;
    edge_t evt;
    logic  mon_active;

    assign role = slave_mode ? ROLE_SLAVE : ROLE_MASTER;

    sws_edge_sync #(.STAGES(SYNC_STAGES)) u_edge (
        .clk (clk),
        .rst (rst),
        .din (sync_in),
        .evt (evt)
    );

    sws_period_gen #(.CNT_W(CNT_W)) u_gen (
        .clk     (clk),
        .rst     (rst),
        .role    (role),
        .enable  (enable),
        .fall    (evt.fall),
        .period  (period),
        .running (running),
        .clk_int (clk_int),
        .out_a   (out_a),
        .out_b   (out_b)
    );

    assign mon_active = (role == ROLE_SLAVE) && running;

    sws_rate_mon #(.CNT_W(CNT_W)) u_mon (
        .clk       (clk),
        .rst       (rst),
        .active    (mon_active),
        .fall      (evt.fall),
        .period    (period),
        .sync_slow (sync_slow)
    );

    always_comb begin
        sync_drive = (role == ROLE_MASTER);
        sync_out   = (role == ROLE_MASTER) && clk_int;
    end

    AST_SLAVE_QUIET: assert property (@(posedge clk) disable iff (rst)
        slave_mode |-> (!sync_drive && !sync_out)); // R2
    AST_IDLE_OUTS: assert property (@(posedge clk) disable iff (rst)
        !running |-> (!clk_int && !out_a && !out_b)); // R6
    AST_MASTER_SLOW0: assert property (@(posedge clk) disable iff (rst)
        !slave_mode |-> !sync_slow); // R9

endmodule

// File: tb/sim_sws_clk_sync.sv
`timescale 1ns/1ps
module sim_sws_clk_sync;
    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             slave_mode = 1'b0;
    logic             enable = 1'b0;
    logic [CNT_W-1:0] period = 16'd20;
    logic             sync_in = 1'b0;
    logic             sync_out, sync_drive, clk_int, out_a, out_b, running, sync_slow;

    int n_run = 0;
    int n_fail = 0;

    bit gen_on = 1'b0;
    bit gen_idle = 1'b0;
    int gen_half = 10;
    int gc = 0;

    int hi_s, hi_c, hi_a, hi_b, r_s, r_c, r_a, both;

    always #2.5 clk = ~clk;

    sws_clk_sync #(.CNT_W(CNT_W), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst(rst), .slave_mode(slave_mode), .enable(enable),
        .period(period), .sync_in(sync_in), .sync_out(sync_out),
        .sync_drive(sync_drive), .clk_int(clk_int), .out_a(out_a),
        .out_b(out_b), .running(running), .sync_slow(sync_slow)
    );

    always @(negedge clk) begin
        if (!gen_on) begin
            gc = 0;
            sync_in = gen_idle;
        end else begin
            sync_in = (gc < gen_half);
            gc = (gc == 2 * gen_half - 1) ? 0 : gc + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic measure(input int win);
        bit ps, pc, pa;
        hi_s = 0; hi_c = 0; hi_a = 0; hi_b = 0; r_s = 0; r_c = 0; r_a = 0; both = 0;
        @(negedge clk);
        ps = sync_out; pc = clk_int; pa = out_a;
        for (int i = 0; i < win; i++) begin
            @(negedge clk);
            hi_s += int'(sync_out); hi_c += int'(clk_int);
            hi_a += int'(out_a); hi_b += int'(out_b);
            if (sync_out && !ps) r_s++;
            if (clk_int && !pc) r_c++;
            if (out_a && !pa) r_a++;
            if (out_a && out_b) both++;
            ps = sync_out; pc = clk_int; pa = out_a;
        end
    endtask

    task automatic do_reset(input bit slv, input int per);
        gen_on = 1'b0; gen_idle = 1'b0;
        @(negedge clk);
        rst = 1'b1; enable = 1'b0; slave_mode = slv; period = CNT_W'(per);
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset;
        do_reset(1'b0, 20);
        @(negedge clk);
        chk(!running && !clk_int && !out_a && !out_b && !sync_out, "R6",
            "reset state idle", int'(running), 0);
        chk(sync_drive == 1'b1, "R1", "master drives line", int'(sync_drive), 1);
    endtask

    task automatic t_master_run;
        do_reset(1'b0, 20);
        repeat (30) @(negedge clk);
        chk(!running && !sync_out, "R6", "master idle without enable", int'(sync_out), 0);
        enable = 1'b1;
        @(posedge clk); #1;
        chk(running && sync_out && out_a && !out_b, "R6", "master starts at first enabled edge",
            int'(running), 1);
        measure(400);
        chk(r_s == 20, "R1", "sync rising edges in 400 cycles", r_s, 20);
        chk(hi_s == 200, "R1", "sync high cycles (50% duty)", hi_s, 200);
        chk(hi_c == 200 && r_c == 20, "R8", "clk_int period 20", r_c, 20);
        chk(hi_a == 200 && hi_b == 200 && r_a == 10, "R7", "A/B alternate each cycle", r_a, 10);
        chk(both == 0, "R7", "A and B overlap", both, 0);
        enable = 1'b0;
        @(posedge clk); #1;
        chk(!running && !clk_int && !sync_out, "R6", "enable low stops master", int'(running), 0);
    endtask

    task automatic t_min_period;
        do_reset(1'b0, 1);
        enable = 1'b1;
        repeat (4) @(negedge clk);
        measure(20);
        chk(hi_s == 10 && r_s == 10, "R8", "period 1 clamped to 2", r_s, 10);
    endtask

    task automatic t_slave;
        do_reset(1'b1, 20);
        enable = 1'b1;
        gen_idle = 1'b1;
        repeat (100) @(negedge clk);
        chk(!running && !clk_int && !out_a, "R4", "slave holds off without pulses", int'(running), 0);
        chk(!sync_drive && !sync_out, "R2", "slave quiet before lock", int'(sync_drive), 0);
        gen_half = 10; gen_on = 1'b1;
        @(negedge sync_in);
        repeat (2) @(posedge clk); #1;
        chk(!running, "R4", "not running two edges after first fall", int'(running), 0);
        @(posedge clk); #1;
        chk(running && clk_int && out_a, "R3", "cycle start three edges after fall",
            int'(clk_int), 1);
        repeat (100) @(negedge clk);
        measure(400);
        chk(r_c == 20 && hi_c == 200, "R3", "slave locked at period 20", r_c, 20);
        chk(hi_s == 0 && !sync_drive, "R2", "slave never drives sync", hi_s, 0);
        chk(!sync_slow, "R9", "20-cycle sync not slow", int'(sync_slow), 0);
        @(negedge sync_in);
        repeat (2) @(posedge clk); #1;
        chk(!clk_int, "R3", "clk_int low before realign", int'(clk_int), 0);
        @(posedge clk); #1;
        chk(clk_int, "R3", "realign in steady lock", int'(clk_int), 1);
        // pulses stop: line held high
        gen_on = 1'b0; gen_idle = 1'b1;
        repeat (60) @(negedge clk);
        measure(400);
        chk(running && r_c == 20 && hi_c == 200, "R5", "free-run after sync loss", r_c, 20);
        chk(sync_slow, "R9", "slow flag after sync loss", int'(sync_slow), 1);
        // slow sync, 40-cycle period
        gen_half = 20; gen_on = 1'b1;
        repeat (200) @(negedge clk);
        chk(sync_slow && running, "R9", "40-cycle sync flagged slow", int'(sync_slow), 1);
        // fast sync, 18-cycle period: early edges restart counter
        gen_half = 9;
        repeat (100) @(negedge clk);
        measure(360);
        chk(r_c == 20 && hi_c == 200, "R3", "early edge shortens cycle to 18", r_c, 20);
        chk(!sync_slow, "R9", "18-cycle sync clears slow", int'(sync_slow), 0);
        enable = 1'b0;
        @(posedge clk); #1;
        chk(!running && !out_a && !out_b && !sync_slow, "R6", "enable low stops slave",
            int'(running), 0);
        gen_on = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_master_run();
        t_min_period();
        t_slave();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule